// File: doc/BRIEF.md
# Video Line Packetizer

This block connects a graphics engine to a wireless link controller. For transmission, the graphics side first writes one compressed video line into a local line buffer, one 5-bit sample at a time. It then requests transmission and supplies the line index. The block cuts the line into fixed 96-bit payloads. Each payload holds an 8-bit segment header, an 8-bit line index and 80 bits of sample data. The block offers the payloads to the link one at a time.

For reception, the block takes payloads from the link. It keeps only the ones that carry video segments and gives their fields to the graphics side, with unused sample slots cleared. Every exchange in both directions follows the same rule: the side that offers something raises a flag and holds it until the other side answers with a one-cycle done pulse. The block ignores a flag during the cycle in which its own done pulse is high, so a requester can drop its flag one cycle after it sees done.

A line has `LINE_SAMPLES` samples, 90 by default. Each segment holds `SEG_SAMPLES` samples, 16 by default. This gives six segments, and the last one is partly filled.

Top module: `video_line_packetizer`

## Requirements
- R1: After a synchronous reset, link_tx_flag, gfx_tx_done, link_rx_done and gfx_rx_valid are all low.
- R2: A transmit request produces ceil(LINE_SAMPLES/SEG_SAMPLES) payloads. Their headers are 1, 2, 3 and so on, in order. Each payload carries the requested line index in link_tx_line.
- R3: In the payload with header h, data bits [5k+4:5k] hold line-buffer sample (h-1)*SEG_SAMPLES+k. Sample 0 is in the least significant 5 bits.
- R4: Any slot whose sample index is LINE_SAMPLES or more is sent as zero. With the defaults, these are slots 10 to 15 of header 6.
- R5: link_tx_flag stays high, with header, line index and data unchanged, until link_tx_done is seen. The flag is low in the cycle after link_tx_done.
- R6: gfx_tx_done pulses once after the link accepts the last segment. No further payload is offered until a new request arrives.
- R7: A link payload whose header is 1 to 6 is answered with link_rx_done. In the same cycle, gfx_rx_valid rises, and gfx_rx_hdr and gfx_rx_line carry the payload's values.
- R8: gfx_rx_valid and the gfx_rx fields stay unchanged until gfx_rx_ack. While gfx_rx_valid is high, no further link payload is accepted.
- R9: A link payload whose header is outside 1 to 6 (for example 0, 7 or 23) is consumed with link_rx_done and never raises gfx_rx_valid.
- R10: In the received data, any slot whose index (h-1)*SEG_SAMPLES+k is LINE_SAMPLES or more is presented as zero. All other slots are passed through unchanged.
- R11: gfx_tx_done and link_rx_done are high for exactly one cycle per exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_wr_en | input | 1 | Line-buffer write strobe |
| lb_wr_addr | input | 7 | Line-buffer sample index |
| lb_wr_sample | input | 5 | Compressed sample to store |
| gfx_tx_req | input | 1 | Graphics side requests transmission of the buffered line |
| gfx_tx_line | input | 8 | Line index for the request |
| gfx_tx_done | output | 1 | Pulse: whole line handed to the link |
| link_tx_flag | output | 1 | Payload offered to the link |
| link_tx_hdr | output | 8 | Segment header of offered payload |
| link_tx_line | output | 8 | Line index of offered payload |
| link_tx_data | output | 80 | Sample data of offered payload |
| link_tx_done | input | 1 | Pulse: link has latched the payload |
| link_rx_flag | input | 1 | Link offers a received payload |
| link_rx_hdr | input | 8 | Received header |
| link_rx_line | input | 8 | Received line index |
| link_rx_data | input | 80 | Received sample data |
| link_rx_done | output | 1 | Pulse: received payload consumed |
| gfx_rx_valid | output | 1 | Decoded segment presented to graphics side |
| gfx_rx_hdr | output | 8 | Segment header presented |
| gfx_rx_line | output | 8 | Line index presented |
| gfx_rx_data | output | 80 | Slot-cleaned sample data presented |
| gfx_rx_ack | input | 1 | Pulse: graphics side has latched the segment |

## Verification
The assertions assume that each requester keeps its flag and fields steady until it sees done, and then drops the flag within a cycle. They also assume that done inputs are one-cycle pulses that arrive only while the matching flag is high. Finally, they assume the line buffer is not rewritten while a line is being sent. The bench drives every handshake from tasks that wait for the flag or done signal at a falling edge, pulse done for one cycle, and lower their flags on the next edge. It writes the line buffer only between transmit requests.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

  localparam int HDR_W   = 8;
  localparam int LNUM_W  = 8;
  localparam int VID_HDR_LAST = 6;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LOAD,
    TX_SEND,
    TX_FIN
  } tx_state_e;

  function automatic logic is_video_hdr(input logic [HDR_W-1:0] h);
    return (h >= HDR_W'(1)) && (h <= HDR_W'(VID_HDR_LAST));
  endfunction

endpackage

// File: rtl/vlp_line_buf.sv
module vlp_line_buf #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 90,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/vlp_tx_segmenter.sv
module vlp_tx_segmenter
  import vlp_pkg::*;
#(
  parameter int SAMPLE_W     = 5,
  parameter int SEG_SAMPLES  = 16,
  parameter int LINE_SAMPLES = 90,
  parameter int AW           = 7
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req,
  input  logic [LNUM_W-1:0]               req_line,
  output logic                            req_done,
  output logic [AW-1:0]                   rd_addr,
  input  logic [SAMPLE_W-1:0]             rd_data,
  output logic                            out_flag,
  output logic [HDR_W-1:0]                out_hdr,
  output logic [LNUM_W-1:0]               out_line,
  output logic [SAMPLE_W*SEG_SAMPLES-1:0] out_data,
  input  logic                            out_done
);

  localparam int NSEG   = (LINE_SAMPLES + SEG_SAMPLES - 1) / SEG_SAMPLES;
  localparam int DATA_W = SAMPLE_W * SEG_SAMPLES;
  localparam int SEG_W  = $clog2(NSEG + 1);
  localparam int CNT_W  = $clog2(SEG_SAMPLES + 1);

  tx_state_e          state;
  logic [SEG_W-1:0]   seg;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  data_q;
  int                 idx;
  logic               rd_in_line;
  logic               prev_in_line;

  // Sample index addressed this cycle; read data arrives one cycle later.
  always_comb begin
    idx          = int'(seg) * SEG_SAMPLES + int'(cnt);
    rd_in_line   = (int'(cnt) < SEG_SAMPLES) && (idx < LINE_SAMPLES);
    prev_in_line = (int'(cnt) > 0) && ((idx - 1) < LINE_SAMPLES);
    rd_addr      = rd_in_line ? AW'(idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      seg      <= '0;
      cnt      <= '0;
      data_q   <= '0;
      req_done <= 1'b0;
      out_flag <= 1'b0;
      out_hdr  <= '0;
      out_line <= '0;
    end else begin
      req_done <= 1'b0;
      case (state)
        TX_IDLE: begin
          if (req && !req_done) begin
            out_line <= req_line;
            seg      <= '0;
            cnt      <= '0;
            state    <= TX_LOAD;
          end
        end
        TX_LOAD: begin
          if (cnt != '0)
            data_q[(int'(cnt) - 1) * SAMPLE_W +: SAMPLE_W] <= prev_in_line ? rd_data : '0;
          if (int'(cnt) == SEG_SAMPLES) begin
            cnt      <= '0;
            out_hdr  <= HDR_W'(int'(seg) + 1);
            out_flag <= 1'b1;
            state    <= TX_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_SEND: begin
          if (out_done) begin
            out_flag <= 1'b0;
            if (int'(seg) == NSEG - 1) begin
              state <= TX_FIN;
            end else begin
              seg   <= seg + 1'b1;
              state <= TX_LOAD;
            end
          end
        end
        default: begin
          req_done <= 1'b1;
          state    <= TX_IDLE;
        end
      endcase
    end
  end

  assign out_data = data_q;

endmodule

// File: rtl/vlp_rx_decoder.sv
module vlp_rx_decoder
  import vlp_pkg::*;
#(
  parameter int SAMPLE_W     = 5,
  parameter int SEG_SAMPLES  = 16,
  parameter int LINE_SAMPLES = 90
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_flag,
  input  logic [HDR_W-1:0]                in_hdr,
  input  logic [LNUM_W-1:0]               in_line,
  input  logic [SAMPLE_W*SEG_SAMPLES-1:0] in_data,
  output logic                            in_done,
  output logic                            out_valid,
  output logic [HDR_W-1:0]                out_hdr,
  output logic [LNUM_W-1:0]               out_line,
  output logic [SAMPLE_W*SEG_SAMPLES-1:0] out_data,
  input  logic                            out_ack
);

  localparam int DATA_W = SAMPLE_W * SEG_SAMPLES;

  logic [DATA_W-1:0] cleaned;

  // Clear the slots that lie beyond the end of the line.
  always_comb begin
    for (int j = 0; j < SEG_SAMPLES; j++) begin
      if ((int'(in_hdr) - 1) * SEG_SAMPLES + j < LINE_SAMPLES)
        cleaned[j*SAMPLE_W +: SAMPLE_W] = in_data[j*SAMPLE_W +: SAMPLE_W];
      else
        cleaned[j*SAMPLE_W +: SAMPLE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_done   <= 1'b0;
      out_valid <= 1'b0;
      out_hdr   <= '0;
      out_line  <= '0;
      out_data  <= '0;
    end else begin
      in_done <= 1'b0;
      if (out_valid) begin
        if (out_ack) out_valid <= 1'b0;
      end else if (in_flag && !in_done) begin
        in_done <= 1'b1;
        if (is_video_hdr(in_hdr)) begin
          out_valid <= 1'b1;
          out_hdr   <= in_hdr;
          out_line  <= in_line;
          out_data  <= cleaned;
        end
      end
    end
  end

endmodule

// File: rtl/video_line_packetizer.sv
module video_line_packetizer
  import vlp_pkg::*;
#(
  parameter int SAMPLE_W     = 5,
  parameter int SEG_SAMPLES  = 16,
  parameter int LINE_SAMPLES = 90,
  parameter int AW           = $clog2(LINE_SAMPLES),
  parameter int DATA_W       = SAMPLE_W * SEG_SAMPLES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lb_wr_en,
  input  logic [AW-1:0]      lb_wr_addr,
  input  logic [SAMPLE_W-1:0] lb_wr_sample,
  input  logic               gfx_tx_req,
  input  logic [LNUM_W-1:0]  gfx_tx_line,
  output logic               gfx_tx_done,
  output logic               link_tx_flag,
  output logic [HDR_W-1:0]   link_tx_hdr,
  output logic [LNUM_W-1:0]  link_tx_line,
  output logic [DATA_W-1:0]  link_tx_data,
  input  logic               link_tx_done,
  input  logic               link_rx_flag,
  input  logic [HDR_W-1:0]   link_rx_hdr,
  input  logic [LNUM_W-1:0]  link_rx_line,
  input  logic [DATA_W-1:0]  link_rx_data,
  output logic               link_rx_done,
  output logic               gfx_rx_valid,
  output logic [HDR_W-1:0]   gfx_rx_hdr,
  output logic [LNUM_W-1:0]  gfx_rx_line,
  output logic [DATA_W-1:0]  gfx_rx_data,
  input  logic               gfx_rx_ack
);

  logic [AW-1:0]       rd_addr;
  logic [SAMPLE_W-1:0] rd_data;

  vlp_line_buf #(
    .WIDTH(SAMPLE_W), .DEPTH(LINE_SAMPLES), .AW(AW)
  ) u_buf (
    .clk     (clk),
    .wr_en   (lb_wr_en),
    .wr_addr (lb_wr_addr),
    .wr_data (lb_wr_sample),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  vlp_tx_segmenter #(
    .SAMPLE_W(SAMPLE_W), .SEG_SAMPLES(SEG_SAMPLES),
    .LINE_SAMPLES(LINE_SAMPLES), .AW(AW)
  ) u_tx (
    .clk      (clk),
    .rst      (rst),
    .req      (gfx_tx_req),
    .req_line (gfx_tx_line),
    .req_done (gfx_tx_done),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .out_flag (link_tx_flag),
    .out_hdr  (link_tx_hdr),
    .out_line (link_tx_line),
    .out_data (link_tx_data),
    .out_done (link_tx_done)
  );

  vlp_rx_decoder #(
    .SAMPLE_W(SAMPLE_W), .SEG_SAMPLES(SEG_SAMPLES),
    .LINE_SAMPLES(LINE_SAMPLES)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .in_flag   (link_rx_flag),
    .in_hdr    (link_rx_hdr),
    .in_line   (link_rx_line),
    .in_data   (link_rx_data),
    .in_done   (link_rx_done),
    .out_valid (gfx_rx_valid),
    .out_hdr   (gfx_rx_hdr),
    .out_line  (gfx_rx_line),
    .out_data  (gfx_rx_data),
    .out_ack   (gfx_rx_ack)
  );

endmodule

// File: rtl/vlp_checker.sv
module vlp_checker #(
  parameter int SEG_SAMPLES  = 16,
  parameter int LINE_SAMPLES = 90,
  parameter int DATA_W       = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              gfx_tx_done,
  input logic              link_tx_flag,
  input logic [7:0]        link_tx_hdr,
  input logic [7:0]        link_tx_line,
  input logic [DATA_W-1:0] link_tx_data,
  input logic              link_tx_done,
  input logic              link_rx_done,
  input logic              gfx_rx_valid,
  input logic [7:0]        gfx_rx_hdr,
  input logic [7:0]        gfx_rx_line,
  input logic [DATA_W-1:0] gfx_rx_data,
  input logic              gfx_rx_ack
);

  localparam int NSEG = (LINE_SAMPLES + SEG_SAMPLES - 1) / SEG_SAMPLES;

  a_r2_hdr_in_range: assert property (@(posedge clk) disable iff (rst)
    link_tx_flag |-> (int'(link_tx_hdr) >= 1 && int'(link_tx_hdr) <= NSEG));

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (link_tx_flag && !link_tx_done) |=> (link_tx_flag && $stable(link_tx_hdr)
      && $stable(link_tx_line) && $stable(link_tx_data)));

  a_r5_tx_drop: assert property (@(posedge clk) disable iff (rst)
    (link_tx_flag && link_tx_done) |=> !link_tx_flag);

  a_r6_done_idle_link: assert property (@(posedge clk) disable iff (rst)
    gfx_tx_done |-> !link_tx_flag);

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (gfx_rx_valid && !gfx_rx_ack) |=> (gfx_rx_valid && $stable(gfx_rx_hdr)
      && $stable(gfx_rx_line) && $stable(gfx_rx_data)));

  a_r8_no_take_while_busy: assert property (@(posedge clk) disable iff (rst)
    (gfx_rx_valid && !gfx_rx_ack) |=> !link_rx_done);

  a_r9_only_video_out: assert property (@(posedge clk) disable iff (rst)
    $rose(gfx_rx_valid) |-> (gfx_rx_hdr >= 8'd1 && gfx_rx_hdr <= 8'd6));

  a_r11_rx_done_pulse: assert property (@(posedge clk) disable iff (rst)
    link_rx_done |=> !link_rx_done);

  a_r11_tx_done_pulse: assert property (@(posedge clk) disable iff (rst)
    gfx_tx_done |=> !gfx_tx_done);

endmodule

bind video_line_packetizer vlp_checker #(
  .SEG_SAMPLES(SEG_SAMPLES), .LINE_SAMPLES(LINE_SAMPLES), .DATA_W(DATA_W)
) u_vlp_checker (
  .clk          (clk),
  .rst          (rst),
  .gfx_tx_done  (gfx_tx_done),
  .link_tx_flag (link_tx_flag),
  .link_tx_hdr  (link_tx_hdr),
  .link_tx_line (link_tx_line),
  .link_tx_data (link_tx_data),
  .link_tx_done (link_tx_done),
  .link_rx_done (link_rx_done),
  .gfx_rx_valid (gfx_rx_valid),
  .gfx_rx_hdr   (gfx_rx_hdr),
  .gfx_rx_line  (gfx_rx_line),
  .gfx_rx_data  (gfx_rx_data),
  .gfx_rx_ack   (gfx_rx_ack)
);

// File: tb/video_line_packetizer_test.sv
`timescale 1ns/1ps
module video_line_packetizer_test;

  localparam int SW = 5, SEG = 16, LINE = 90, AW = 7, DW = 80;
  localparam int NSEG = (LINE + SEG - 1) / SEG;

  logic clk = 1'b0, rst = 1'b1;
  logic lb_wr_en = 0; logic [AW-1:0] lb_wr_addr = '0; logic [SW-1:0] lb_wr_sample = '0;
  logic gfx_tx_req = 0; logic [7:0] gfx_tx_line = '0; logic gfx_tx_done;
  logic link_tx_flag; logic [7:0] link_tx_hdr, link_tx_line; logic [DW-1:0] link_tx_data;
  logic link_tx_done = 0;
  logic link_rx_flag = 0; logic [7:0] link_rx_hdr = '0, link_rx_line = '0; logic [DW-1:0] link_rx_data = '0;
  logic link_rx_done, gfx_rx_valid; logic [7:0] gfx_rx_hdr, gfx_rx_line; logic [DW-1:0] gfx_rx_data;
  logic gfx_rx_ack = 0;

  int n_checks = 0, n_fail = 0;
  logic [SW-1:0] model [LINE];

  always #2.5 clk = ~clk;

  video_line_packetizer uut (.*);

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_tx(input int s);
    logic [DW-1:0] d = '0;
    for (int k = 0; k < SEG; k++)
      if (s * SEG + k < LINE) d[k*SW +: SW] = model[s*SEG + k];
    return d;
  endfunction

  function automatic logic [DW-1:0] exp_rx(input int h, input logic [DW-1:0] d);
    logic [DW-1:0] r = '0;
    for (int k = 0; k < SEG; k++)
      if ((h - 1) * SEG + k < LINE) r[k*SW +: SW] = d[k*SW +: SW];
    return r;
  endfunction

  task automatic write_line(input int seed);
    for (int i = 0; i < LINE; i++) begin
      @(posedge clk); #1;
      model[i] = SW'((i * 7 + seed * 3 + (i >> 2)) % 32);
      lb_wr_en = 1; lb_wr_addr = AW'(i); lb_wr_sample = model[i];
    end
    @(posedge clk); #1 lb_wr_en = 0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 reset flags", {92'd0, link_tx_flag, gfx_tx_done, link_rx_done, gfx_rx_valid}, 96'd0);
  endtask

  task automatic test_tx_line(input logic [7:0] ln, input int dly);
    int stray = 0;
    @(posedge clk); #1 gfx_tx_req = 1; gfx_tx_line = ln;
    for (int s = 0; s < NSEG; s++) begin
      @(negedge clk);
      while (!link_tx_flag) @(negedge clk);
      chk("R2 header order", {88'd0, link_tx_hdr}, 96'(s + 1));
      chk("R2 line index", {88'd0, link_tx_line}, {88'd0, ln});
      if (s == NSEG - 1) chk("R4 last segment zero fill", {16'd0, link_tx_data}, {16'd0, exp_tx(s)});
      else               chk("R3 segment data", {16'd0, link_tx_data}, {16'd0, exp_tx(s)});
      for (int w = 0; w < dly; w++) begin
        @(negedge clk);
        chk("R5 hold until done", {8'd0, link_tx_flag, link_tx_hdr[6:0], link_tx_data},
            {8'd0, 1'b1, 7'(s + 1), exp_tx(s)});
      end
      @(posedge clk); #1 link_tx_done = 1;
      @(posedge clk); #1 link_tx_done = 0;
      @(negedge clk);
      chk("R5 flag drops after done", {95'd0, link_tx_flag}, 96'd0);
    end
    while (!gfx_tx_done) @(negedge clk);
    chk("R6 line done", {95'd0, gfx_tx_done}, 96'd1);
    @(posedge clk); #1 gfx_tx_req = 0;
    @(negedge clk);
    chk("R11 tx done single cycle", {95'd0, gfx_tx_done}, 96'd0);
    for (int w = 0; w < 30; w++) begin
      @(negedge clk);
      if (link_tx_flag) stray++;
    end
    chk("R6 nothing offered without request", 96'(stray), 96'd0);
  endtask

  task automatic rx_offer(input logic [7:0] h, input logic [7:0] l, input logic [DW-1:0] d);
    @(posedge clk); #1 link_rx_flag = 1; link_rx_hdr = h; link_rx_line = l; link_rx_data = d;
  endtask

  task automatic rx_wait_done();
    @(negedge clk);
    while (!link_rx_done) @(negedge clk);
    @(posedge clk); #1 link_rx_flag = 0;
    @(negedge clk);
    chk("R11 rx done single cycle", {95'd0, link_rx_done}, 96'd0);
  endtask

  task automatic rx_ack();
    @(posedge clk); #1 gfx_rx_ack = 1;
    @(posedge clk); #1 gfx_rx_ack = 0;
    @(negedge clk);
    chk("R8 valid clears on ack", {95'd0, gfx_rx_valid}, 96'd0);
  endtask

  task automatic test_rx_video(input logic [7:0] h, input logic [7:0] l, input logic [DW-1:0] d,
                               input int dly, input string req);
    rx_offer(h, l, d);
    @(negedge clk);
    while (!link_rx_done) @(negedge clk);
    chk("R7 valid with done", {95'd0, gfx_rx_valid}, 96'd1);
    chk("R7 header and line", {80'd0, gfx_rx_hdr, gfx_rx_line}, {80'd0, h, l});
    chk(req, {16'd0, gfx_rx_data}, {16'd0, exp_rx(int'(h), d)});
    @(posedge clk); #1 link_rx_flag = 0;
    for (int w = 0; w < dly; w++) begin
      @(negedge clk);
      chk("R8 presented fields held", {7'd0, gfx_rx_valid, gfx_rx_hdr, gfx_rx_data},
          {7'd0, 1'b1, h, exp_rx(int'(h), d)});
    end
    rx_ack();
  endtask

  task automatic test_rx_drop(input logic [7:0] h);
    int seen = 0;
    rx_offer(h, 8'd9, {DW{1'b1}});
    rx_wait_done();
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      if (gfx_rx_valid) seen++;
    end
    chk("R9 non-video header not forwarded", 96'(seen), 96'd0);
  endtask

  task automatic test_rx_backpressure();
    int early = 0;
    logic [DW-1:0] d1 = {16{5'h0A}};
    logic [DW-1:0] d2 = {16{5'h15}};
    rx_offer(8'd1, 8'd40, d1);
    rx_wait_done();
    rx_offer(8'd3, 8'd41, d2);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      if (link_rx_done) early++;
    end
    chk("R8 no accept while presenting", 96'(early), 96'd0);
    chk("R8 first segment still shown", {16'd0, gfx_rx_data}, {16'd0, d1});
    rx_ack();
    @(negedge clk);
    while (!link_rx_done) @(negedge clk);
    chk("R8 second accepted after ack", {80'd0, gfx_rx_hdr, gfx_rx_line}, {80'd0, 8'd3, 8'd41});
    @(posedge clk); #1 link_rx_flag = 0;
    rx_ack();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    test_reset();
    write_line(3);
    test_tx_line(8'h11, 0);
    write_line(17);
    test_tx_line(8'd126, 3);
    test_rx_video(8'd2, 8'd5, 80'h1234_5678_9ABC_DEF0_1357, 2, "R7 data passed");
    test_rx_video(8'd6, 8'd77, {DW{1'b1}}, 0, "R10 tail slots cleared");
    test_rx_drop(8'd0);
    test_rx_drop(8'd7);
    test_rx_drop(8'd23);
    test_rx_backpressure();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule